// File: doc/BRIEF.md
# AC'97 Codec Register Bank

This block holds the codec control words of an AC'97-style audio link: 64 words of 16 bits, each addressed by an even 7-bit register address. A simple command port carries a write strobe, a read strobe, an address and write data. Every read produces a slot-formatted response: a pair of slot-valid tag bits, the echoed address for slot 1 and the data word for slot 2.

Writes are filtered per register. Some are dropped, some are replaced by a constant and some have fixed bit patterns merged in. Reads are also rewritten per register. Identification bits follow a strap pin, a power-control bit reports a live control flop, and the three playback-rate registers report a rate chosen by an internal flag. A compliance mode clears reserved bits on read. That mode is selected by a configuration word, and it is the mode the block comes out of reset in.

Top module: `ac97_regbank`

## Requirements
- R1: A read accepted on a rising edge yields `rsp_valid` high after the second following rising edge, for exactly one cycle, with `rsp_slot_tag` = 2'b11 and `rsp_addr` equal to the read address. When no response is due, `rsp_valid` is low and `rsp_slot_tag` is 2'b00.
- R2: A read of an odd address returns all-zero data. The odd address is echoed and the tag is 2'b11. A write to an odd address changes nothing.
- R3: Writes to 7Ch, 7Eh and 28h are dropped. 7Ch reads as the VENDOR_ID1 parameter (default 4142h) and 7Eh reads as VENDOR_ID2 (default 4C31h). 28h reads as EXT_ID (default 8205h), subject to R7.
- R4: A write to 26h stores the upper 12 data bits with the low nibble forced to 1110.
- R5: A write to 2Ah stores the data with bits 9:6 forced to 0111.
- R6: Any write to 32h or 34h stores BB80h, whatever the data.
- R7: On a read of 28h or 3Ch, bit 15 is 0 and bit 14 equals the `strap_sa` input. The other bits come from the word held for that address.
- R8: Bit 12 of a 26h write sets the link-low flop, which drives `link_low_o`. A read of 26h returns that flop in bit 12. A `warm_rst` pulse clears the flop.
- R9: A write to 2Ch, 2Eh or 30h sets the rate flag when the data equals AC44h and clears it otherwise. A read of any of the three returns AC44h when the flag is set and BB80h when it is clear.
- R10: Bit 0 of 5Ah set selects raw mode. In raw mode reads return the unmasked word. With the bit clear (compliance mode), reads are ANDed with a per-address mask: 02h/04h 9F1Fh, 26h FF0Fh, 2Ah 3BFFh, 28h/3Ch C3FFh, 5Ah 0001h, and FFFFh elsewhere.
- R11: `rst` or a write to 00h returns the link-low flop, the rate flag and the mode bit to 0. The stored words are kept.
- R12: A write to any other even address stores the data unchanged, and a later read returns it, masked as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| warm_rst | input | 1 | Warm-reset pulse; clears the link-low flop |
| strap_sa | input | 1 | Strap pin reported in ID bit 14 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register address |
| wr_data | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_slot_tag | output | 2 | Slot-0 valid bits for slots 1 and 2 |
| rsp_addr | output | 7 | Slot-1 echoed address |
| rsp_data | output | 16 | Slot-2 read data |
| link_low_o | output | 1 | Live link-low control flop |

## Verification
Read responses are due two rising edges after the read strobe is sampled: one edge for the storage read and the control-state snapshot, one for the rewrite and output register. The scoreboard pushes each expected word when it issues the read. The monitor pops on every falling edge where `rsp_valid` is high, so order and latency are both checked. Control-flop effects on `link_low_o` become visible one edge after the write or warm-reset pulse and are sampled at the next falling edge. A read issued straight after a write sees the new word, because the storage read happens on the edge after the write.

// File: rtl/ac97_regbank_pkg.sv
package ac97_regbank_pkg;

  localparam logic [6:0] RA_SOFT_RESET = 7'h00;
  localparam logic [6:0] RA_MASTER_VOL = 7'h02;
  localparam logic [6:0] RA_HP_VOL     = 7'h04;
  localparam logic [6:0] RA_POWER      = 7'h26;
  localparam logic [6:0] RA_EXT_ID     = 7'h28;
  localparam logic [6:0] RA_EXT_CTRL   = 7'h2A;
  localparam logic [6:0] RA_RATE_FRONT = 7'h2C;
  localparam logic [6:0] RA_RATE_SURR  = 7'h2E;
  localparam logic [6:0] RA_RATE_LFE   = 7'h30;
  localparam logic [6:0] RA_ADC_RATE_A = 7'h32;
  localparam logic [6:0] RA_ADC_RATE_B = 7'h34;
  localparam logic [6:0] RA_MODEM_ID   = 7'h3C;
  localparam logic [6:0] RA_CONFIG     = 7'h5A;
  localparam logic [6:0] RA_VENDOR_1   = 7'h7C;
  localparam logic [6:0] RA_VENDOR_2   = 7'h7E;

  localparam logic [15:0] RATE_48K = 16'hBB80;
  localparam logic [15:0] RATE_44K = 16'hAC44;

  localparam int unsigned LINK_LOW_BIT = 12;
  localparam int unsigned ID_STRAP_BIT = 14;
  localparam int unsigned ID_ZERO_BIT  = 15;

  typedef struct packed {
    logic link_low;
    logic rate_44k;
    logic raw_mode;
  } ctrl_t;

  function automatic logic [15:0] read_mask(input logic [6:0] a);
    logic [15:0] m;
    case (a)
      RA_MASTER_VOL, RA_HP_VOL: m = 16'h9F1F;
      RA_POWER:                 m = 16'hFF0F;
      RA_EXT_CTRL:              m = 16'h3BFF;
      RA_EXT_ID, RA_MODEM_ID:   m = 16'hC3FF;
      RA_CONFIG:                m = 16'h0001;
      default:                  m = 16'hFFFF;
    endcase
    return m;
  endfunction

  function automatic logic is_rate_reg(input logic [6:0] a);
    return (a == RA_RATE_FRONT) || (a == RA_RATE_SURR) || (a == RA_RATE_LFE);
  endfunction

endpackage

// File: rtl/ac97_wr_filter.sv
module ac97_wr_filter
  import ac97_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = ADDR_W - 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              soft_rst,
  output logic              link_we,
  output logic              link_val,
  output logic              rate_we,
  output logic              rate_val,
  output logic              cfg_we,
  output logic              cfg_val
);

  logic even;
  assign even    = wr_en && !addr[0];
  assign mem_idx = addr[ADDR_W-1:1];

  always_comb begin
    mem_we    = even;
    mem_wdata = wr_data;
    soft_rst  = 1'b0;
    link_we   = 1'b0;
    link_val  = wr_data[LINK_LOW_BIT];
    rate_we   = 1'b0;
    rate_val  = (wr_data == RATE_44K);
    cfg_we    = 1'b0;
    cfg_val   = wr_data[0];
    if (even) begin
      case (addr)
        RA_SOFT_RESET: begin
          mem_we   = 1'b0;
          soft_rst = 1'b1;
        end
        RA_VENDOR_1, RA_VENDOR_2, RA_EXT_ID: mem_we = 1'b0;
        RA_POWER: begin
          mem_wdata = {wr_data[DATA_W-1:4], 4'b1110};
          link_we   = 1'b1;
        end
        RA_EXT_CTRL: mem_wdata = {wr_data[DATA_W-1:10], 4'b0111, wr_data[5:0]};
        RA_ADC_RATE_A, RA_ADC_RATE_B: mem_wdata = RATE_48K;
        RA_RATE_FRONT, RA_RATE_SURR, RA_RATE_LFE: rate_we = 1'b1;
        RA_CONFIG: cfg_we = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ac97_ctrl_flops.sv
module ac97_ctrl_flops
  import ac97_regbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  soft_rst,
  input  logic  warm_rst,
  input  logic  link_we,
  input  logic  link_val,
  input  logic  rate_we,
  input  logic  rate_val,
  input  logic  cfg_we,
  input  logic  cfg_val,
  output ctrl_t ctrl
);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl <= '0;
    end else begin
      if (warm_rst)     ctrl.link_low <= 1'b0;
      else if (link_we) ctrl.link_low <= link_val;
      if (rate_we) ctrl.rate_44k <= rate_val;
      if (cfg_we)  ctrl.raw_mode <= cfg_val;
    end
  end

endmodule

// File: rtl/ac97_word_ram.sv
module ac97_word_ram #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end

endmodule

// File: rtl/ac97_rd_shaper.sv
module ac97_rd_shaper
  import ac97_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  parameter logic [15:0] VENDOR_ID1 = 16'h4142,
  parameter logic [15:0] VENDOR_ID2 = 16'h4C31,
  parameter logic [15:0] EXT_ID     = 16'h8205
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl,
  input  logic              strap_sa,
  input  logic [DATA_W-1:0] ram_q,
  output logic              rsp_valid,
  output logic [1:0]        rsp_slot_tag,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);

  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  ctrl_t             s1_ctrl;
  logic              s1_strap;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_ctrl  <= '0;
      s1_strap <= 1'b0;
    end else begin
      s1_valid <= rd_en;
      if (rd_en) begin
        s1_addr  <= addr;
        s1_ctrl  <= ctrl;
        s1_strap <= strap_sa;
      end
    end
  end

  always_comb begin
    word = ram_q;
    case (s1_addr)
      RA_VENDOR_1: word = VENDOR_ID1;
      RA_VENDOR_2: word = VENDOR_ID2;
      RA_EXT_ID:   word = EXT_ID;
      default: ;
    endcase
    if (s1_addr == RA_EXT_ID || s1_addr == RA_MODEM_ID) begin
      word[ID_ZERO_BIT]  = 1'b0;
      word[ID_STRAP_BIT] = s1_strap;
    end
    if (s1_addr == RA_POWER) word[LINK_LOW_BIT] = s1_ctrl.link_low;
    if (is_rate_reg(s1_addr)) word = s1_ctrl.rate_44k ? RATE_44K : RATE_48K;
    if (!s1_ctrl.raw_mode) word = word & read_mask(s1_addr);
    if (s1_addr[0]) word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_slot_tag <= 2'b00;
      rsp_addr     <= '0;
      rsp_data     <= '0;
    end else begin
      rsp_valid    <= s1_valid;
      rsp_slot_tag <= {s1_valid, s1_valid};
      rsp_addr     <= s1_valid ? s1_addr : '0;
      rsp_data     <= s1_valid ? word : '0;
    end
  end

endmodule

// File: rtl/ac97_regbank.sv
module ac97_regbank
  import ac97_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  parameter logic [15:0] VENDOR_ID1 = 16'h4142,
  parameter logic [15:0] VENDOR_ID2 = 16'h4C31,
  parameter logic [15:0] EXT_ID     = 16'h8205,
  localparam int unsigned IDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              strap_sa,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_slot_tag,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              link_low_o
);

  logic              mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wdata;
  logic              soft_rst, link_we, link_val, rate_we, rate_val, cfg_we, cfg_val;
  logic [DATA_W-1:0] ram_q;
  ctrl_t             ctrl;

  ac97_wr_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_filter (
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
    .soft_rst(soft_rst), .link_we(link_we), .link_val(link_val),
    .rate_we(rate_we), .rate_val(rate_val), .cfg_we(cfg_we), .cfg_val(cfg_val)
  );

  ac97_ctrl_flops u_ctrl (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .warm_rst(warm_rst),
    .link_we(link_we), .link_val(link_val), .rate_we(rate_we), .rate_val(rate_val),
    .cfg_we(cfg_we), .cfg_val(cfg_val), .ctrl(ctrl)
  );

  ac97_word_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(mem_we), .widx(mem_idx), .wdata(mem_wdata),
    .ridx(addr[ADDR_W-1:1]), .rdata(ram_q)
  );

  ac97_rd_shaper #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VENDOR_ID1(VENDOR_ID1), .VENDOR_ID2(VENDOR_ID2), .EXT_ID(EXT_ID)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .ctrl(ctrl),
    .strap_sa(strap_sa), .ram_q(ram_q),
    .rsp_valid(rsp_valid), .rsp_slot_tag(rsp_slot_tag),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  assign link_low_o = ctrl.link_low;

endmodule

// File: rtl/ac97_regbank_chk.sv
module ac97_regbank_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              warm_rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rsp_valid,
  input logic [1:0]        rsp_slot_tag,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [DATA_W-1:0] rsp_data,
  input logic              link_low_o
);

  AST_RSP_DUE: assert property (@(posedge clk) disable iff (rst) rd_en |=> ##1 rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !rd_en |=> ##1 !rsp_valid); // R1
  AST_TAG_WITH_RSP: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> rsp_slot_tag == 2'b11); // R1
  AST_TAG_IDLE: assert property (@(posedge clk) disable iff (rst) !rsp_valid |-> rsp_slot_tag == 2'b00); // R1
  AST_ODD_ZERO: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_addr[0]) |-> rsp_data == '0); // R2
  AST_ID_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_addr == 7'h28 || rsp_addr == 7'h3C)) |-> !rsp_data[15]); // R7
  AST_RATE_CODE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_addr == 7'h2C || rsp_addr == 7'h2E || rsp_addr == 7'h30))
      |-> (rsp_data == 16'hBB80 || rsp_data == 16'hAC44)); // R9
  AST_WARM_CLEAR: assert property (@(posedge clk) disable iff (rst) warm_rst |=> !link_low_o); // R8
  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!warm_rst && !(wr_en && (addr == 7'h26 || addr == 7'h00))) |=> $stable(link_low_o)); // R8
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == 7'h00) |=> !link_low_o); // R11

endmodule

bind ac97_regbank ac97_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rsp_valid(rsp_valid), .rsp_slot_tag(rsp_slot_tag), .rsp_addr(rsp_addr),
  .rsp_data(rsp_data), .link_low_o(link_low_o)
);

// File: tb/ac97_regbank_bench.sv
module ac97_regbank_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst, warm_rst, strap_sa, wr_en, rd_en;
  logic [6:0]  addr;
  logic [15:0] wr_data;
  logic        rsp_valid, link_low_o;
  logic [1:0]  rsp_slot_tag;
  logic [6:0]  rsp_addr;
  logic [15:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [6:0]  q_addr[$];
  logic [15:0] q_data[$];
  string       q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ac97_regbank u_ac97_regbank (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .strap_sa(strap_sa),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_slot_tag(rsp_slot_tag), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .link_low_o(link_low_o)
  );

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string req);
    q_addr.push_back(a); q_data.push_back(exp); q_req.push_back(req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_link(input logic exp, input string req);
    checks++;
    if (link_low_o !== exp) begin
      fails++;
      $display("FAIL %s link_low_o actual %0b expected %0b", req, link_low_o, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response is presented
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid === 1'b1) begin
        checks++;
        if (q_data.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected response actual addr %h data %h expected none", rsp_addr, rsp_data);
        end else begin
          automatic logic [6:0]  ea = q_addr.pop_front();
          automatic logic [15:0] ed = q_data.pop_front();
          automatic string       er = q_req.pop_front();
          if (rsp_data !== ed || rsp_addr !== ea || rsp_slot_tag !== 2'b11) begin
            fails++;
            $display("FAIL %s actual addr %h tag %b data %h expected addr %h tag 11 data %h",
                     er, rsp_addr, rsp_slot_tag, rsp_data, ea, ed);
          end
        end
      end
    end
  end

  initial begin
    for (int n = 0; n < WATCHDOG && !done; n++) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; warm_rst = 1'b0; strap_sa = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_slot_tag !== 2'b00) begin
      fails++;
      $display("FAIL R1 reset response actual %b/%b expected 0/00", rsp_valid, rsp_slot_tag);
    end
    rst = 1'b0;
    chk_link(1'b0, "R11 reset");
    rd(7'h2C, 16'hBB80, "R9 reset rate");
    rd(7'h7C, 16'h4142, "R3 vendor1 reset");

    // R12 / R10 compliance masking
    wr(7'h02, 16'hA5A5);
    rd(7'h02, 16'h8505, "R10 masked volume");
    wr(7'h5A, 16'h0001);
    rd(7'h02, 16'hA5A5, "R12 raw volume");
    rd(7'h5A, 16'h0001, "R12 config word");
    wr(7'h10, 16'h5A3C);
    rd(7'h10, 16'h5A3C, "R12 plain register");

    // R3 dropped writes
    wr(7'h7C, 16'h0000);
    wr(7'h7E, 16'h1234);
    wr(7'h28, 16'hFFFF);
    rd(7'h7C, 16'h4142, "R3 vendor1");
    rd(7'h7E, 16'h4C31, "R3 vendor2");
    rd(7'h28, 16'h0205, "R3 R7 ext id strap0");

    // R7 strap
    strap_sa = 1'b1;
    rd(7'h28, 16'h4205, "R7 ext id strap1");
    wr(7'h3C, 16'h8001);
    rd(7'h3C, 16'h4001, "R7 modem id");

    // R4 / R8
    wr(7'h26, 16'hFFFF);
    chk_link(1'b1, "R8 set");
    rd(7'h26, 16'hFFFE, "R4 R8 power all ones");
    wr(7'h26, 16'h0005);
    chk_link(1'b0, "R8 cleared by write");
    rd(7'h26, 16'h000E, "R4 power nibble");
    wr(7'h26, 16'h1000);
    rd(7'h26, 16'h100E, "R8 live bit set");
    warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    chk_link(1'b0, "R8 warm reset");
    rd(7'h26, 16'h000E, "R8 live bit after warm reset");

    // R5
    wr(7'h2A, 16'hFFFF);
    rd(7'h2A, 16'hFDFF, "R5 ext ctrl ones");
    wr(7'h2A, 16'h0000);
    rd(7'h2A, 16'h01C0, "R5 ext ctrl zeros");

    // R6
    wr(7'h32, 16'h1234);
    wr(7'h34, 16'h0000);
    rd(7'h32, 16'hBB80, "R6 adc rate a");
    rd(7'h34, 16'hBB80, "R6 adc rate b");

    // R9
    wr(7'h2E, 16'hAC44);
    rd(7'h2C, 16'hAC44, "R9 front after 44k");
    rd(7'h2E, 16'hAC44, "R9 surround after 44k");
    rd(7'h30, 16'hAC44, "R9 lfe after 44k");
    wr(7'h30, 16'h1111);
    rd(7'h2C, 16'hBB80, "R9 back to 48k");
    wr(7'h2C, 16'hAC44);
    rd(7'h30, 16'hAC44, "R9 front write flips all");

    // R2 odd addresses
    wr(7'h11, 16'hFFFF);
    rd(7'h03, 16'h0000, "R2 odd 03");
    rd(7'h7F, 16'h0000, "R2 odd 7F");
    rd(7'h10, 16'h5A3C, "R2 odd write ignored");

    // R11 soft reset
    wr(7'h26, 16'h1000);
    wr(7'h00, 16'h0000);
    chk_link(1'b0, "R11 soft reset link");
    rd(7'h2C, 16'hBB80, "R11 soft reset rate");
    rd(7'h02, 16'h8505, "R11 soft reset mode");
    rd(7'h3C, 16'h4001, "R10 modem id masked");
    rd(7'h28, 16'h4205, "R10 ext id masked");
    rd(7'h26, 16'h000E, "R10 power masked");
    rd(7'h2A, 16'h01C0, "R10 ext ctrl masked");

    // R11 hard reset keeps words, clears mode
    wr(7'h5A, 16'h0001);
    wr(7'h26, 16'h1000);
    repeat (3) @(negedge clk);
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    chk_link(1'b0, "R11 hard reset link");
    rd(7'h02, 16'h8505, "R11 hard reset mode");

    repeat (4) @(negedge clk);
    checks++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R1 missing responses actual %0d pending expected 0", q_data.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule